// File: doc/BRIEF.md
# Safety Configuration Lock Controller

This block guards the configuration of a safety monitor. It holds a small control register with three bits: a master enable, a lock bit that can only be set, and a test-injection enable. It also qualifies every configuration write that software issues to the per-bank routing words, the per-bank inject registers and the grace-period reload value. Each routing write leaves the block as a strobe with a bit mask. The storage that sits downstream uses the mask to decide which bits it may change. The inject registers and the reload value are stored in this block, because the lock has to clear or freeze them directly.

Once the lock is set, the configuration is fixed for the rest of the run. In the same clock update, test injection is switched off and every inject register is cleared. From then on the two high-severity routing fields of every bank can no longer be changed, the reload value is frozen, and the master enable can be turned on but never turned off. The two low-severity routing fields stay writable.

A parameter can remove the lock feature entirely. In that build the lock bit always reads 0, and every write behaves as it does in the unlocked state.

Top module: `safety_cfg_lock`

## Requirements
- R1: After a synchronous reset, the enable, lock and injection-enable outputs are 0, every inject register bit is 0 and the reload value is 0.
- R2: A control write takes bit 0 as the master enable, bit 1 as the lock and bit 2 as the injection enable. When unlocked, each bit takes the written value on the next cycle.
- R3: Once the lock is set, it stays set until reset, whatever value later control writes carry in bit 1.
- R4: The control write that sets the lock also clears the injection enable and zeroes every bank's inject register, all in the same update. This holds even when that same write sets bit 2.
- R5: While locked, a control write with bit 2 set leaves the injection enable at 0.
- R6: While locked, a control write with bit 0 clear leaves the master enable unchanged, and a write with bit 0 set still turns it on.
- R7: A bank write with bank_reg_i = 0 (routing word) and a bank number below the bank count raises route_wr_o in the same cycle. The strobe carries the bank number and passes the data through unchanged. The mask has, in each of the four bytes, one bit for each input that exists in that bank: the last bank may be partial. A bank number at or above the bank count raises no strobe.
- R8: While locked, the routing mask has bits [31:16] (the two high-severity fields) at 0, and bits [15:0] are as in R7.
- R9: A bank write with bank_reg_i = 1 (inject) stores bank_data_i[7:0], masked to the bank's existing inputs, into bits [8b+7:8b] of inject_o on the next cycle. This happens only while the injection enable is 1 and the lock is clear; otherwise the inject bits are unchanged.
- R10: A reload write updates reload_o on the next cycle while unlocked. While locked it is ignored.
- R11: With HAS_LOCK = 0, lock_o always reads 0 and reload writes are always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_data_i | input | 3 | Control write data: bit2 injection enable, bit1 lock, bit0 enable |
| bank_wr_i | input | 1 | Per-bank register write strobe |
| bank_reg_i | input | 1 | Bank register select: 0 routing word, 1 inject |
| bank_sel_i | input | BANK_W | Bank number |
| bank_data_i | input | 32 | Bank write data |
| reload_wr_i | input | 1 | Reload value write strobe |
| reload_data_i | input | CNT_W | Reload write data |
| enable_o | output | 1 | Master enable |
| lock_o | output | 1 | Lock state |
| inject_en_o | output | 1 | Injection enable |
| route_wr_o | output | 1 | Qualified routing-word write strobe |
| route_bank_o | output | BANK_W | Bank of the routing write |
| route_mask_o | output | 32 | Bits the routing write may change |
| route_data_o | output | 32 | Routing write data |
| inject_o | output | NBANK*8 | Inject register contents, 8 bits per bank |
| reload_o | output | CNT_W | Grace-period reload value |

## Verification
A corrupted lock bit shows up on the next cycle in several places at once. lock_o changes, the high half of route_mask_o changes within the same cycle as any routing write, and the next reload or inject write is wrongly accepted or refused, which is visible one cycle later on reload_o or inject_o. A corrupted injection enable or inject register shows up on inject_en_o or inject_o one cycle after the control or inject write that exposes it. A wrong lane table for a partial bank shows up directly in the routing mask.

// File: rtl/safety_lock_pkg.sv
package safety_lock_pkg;

    localparam int LANES = 8;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] LOW_SEV_FIELDS = 32'h0000_FFFF;

    typedef struct packed {
        logic inj_en;
        logic lock;
        logic en;
    } ctrl_t;

    typedef enum logic {
        BANK_ROUTE  = 1'b0,
        BANK_INJECT = 1'b1
    } bank_reg_e;

    function automatic int banks_for(input int inputs);
        return (inputs + LANES - 1) / LANES;
    endfunction

    function automatic logic [LANES-1:0] lanes_of_bank(input int bank, input int inputs);
        int n;
        n = inputs - bank * LANES;
        if (n >= LANES) return '1;
        if (n <= 0) return '0;
        return LANES'((1 << n) - 1);
    endfunction

    function automatic ctrl_t ctrl_next(input ctrl_t cur, input ctrl_t wr, input bit has_lock);
        ctrl_t nx;
        nx.lock   = has_lock & (cur.lock | wr.lock);
        nx.en     = cur.lock ? (cur.en | wr.en) : wr.en;
        nx.inj_en = nx.lock ? 1'b0 : wr.inj_en;
        return nx;
    endfunction

endpackage

// File: rtl/lock_ctrl_reg.sv
module lock_ctrl_reg
    import safety_lock_pkg::*;
#(
    parameter bit HAS_LOCK = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_i,
    input  ctrl_t wr_data_i,
    output ctrl_t ctrl_o,
    output logic  lock_set_o
);

    ctrl_t cur_q;
    ctrl_t nxt;

    always_comb begin
        nxt = ctrl_next(cur_q, wr_data_i, HAS_LOCK);
        lock_set_o = wr_i & nxt.lock & ~cur_q.lock;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (wr_i) begin
            cur_q <= nxt;
        end
    end

    assign ctrl_o = cur_q;

endmodule

// File: rtl/lock_inject_bank.sv
module lock_inject_bank
    import safety_lock_pkg::*;
#(
    parameter logic [LANES-1:0] LANE_MASK = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [LANES-1:0] data_i,
    input  logic             clear_i,
    output logic [LANES-1:0] bits_o
);

    logic [LANES-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            bits_q <= '0;
        end else if (wr_i) begin
            bits_q <= data_i & LANE_MASK;
        end
    end

    assign bits_o = bits_q;

endmodule

// File: rtl/lock_reload_reg.sv
module lock_reload_reg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    input  logic         frozen_i,
    output logic [W-1:0] value_o
);

    logic [W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (wr_i && !frozen_i) begin
            value_q <= data_i;
        end
    end

    assign value_o = value_q;

endmodule

// File: rtl/safety_cfg_lock.sv
module safety_cfg_lock
    import safety_lock_pkg::*;
#(
    parameter int INPUTS   = 32,
    parameter int CNT_W    = 24,
    parameter bit HAS_LOCK = 1'b1,
    localparam int NBANK   = banks_for(INPUTS),
    localparam int BANK_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int INJ_W   = NBANK * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr_i,
    input  logic [2:0]        ctrl_data_i,
    input  logic              bank_wr_i,
    input  logic              bank_reg_i,
    input  logic [BANK_W-1:0] bank_sel_i,
    input  logic [WORD_W-1:0] bank_data_i,
    input  logic              reload_wr_i,
    input  logic [CNT_W-1:0]  reload_data_i,
    output logic              enable_o,
    output logic              lock_o,
    output logic              inject_en_o,
    output logic              route_wr_o,
    output logic [BANK_W-1:0] route_bank_o,
    output logic [WORD_W-1:0] route_mask_o,
    output logic [WORD_W-1:0] route_data_o,
    output logic [INJ_W-1:0]  inject_o,
    output logic [CNT_W-1:0]  reload_o
);

    ctrl_t            ctrl;
    logic             lock_set;
    logic             bank_hit;
    logic [LANES-1:0] sel_lanes;
    logic [LANES-1:0] lane_tbl [NBANK];
    bank_reg_e        reg_kind;
    logic             inject_ok;

    lock_ctrl_reg #(.HAS_LOCK(HAS_LOCK)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (ctrl_wr_i),
        .wr_data_i  (ctrl_t'(ctrl_data_i)),
        .ctrl_o     (ctrl),
        .lock_set_o (lock_set)
    );

    always_comb begin
        bank_hit  = 1'b0;
        sel_lanes = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (int'(bank_sel_i) == b) begin
                bank_hit  = 1'b1;
                sel_lanes = lane_tbl[b];
            end
        end
    end

    assign reg_kind  = bank_reg_e'(bank_reg_i);
    assign inject_ok = ctrl.inj_en & ~ctrl.lock;

    // routing write: strobe and mask only, storage lives downstream
    always_comb begin
        route_wr_o   = bank_wr_i && bank_hit && (reg_kind == BANK_ROUTE);
        route_bank_o = bank_sel_i;
        route_data_o = bank_data_i;
        route_mask_o = {4{sel_lanes}};
        if (ctrl.lock) begin
            route_mask_o = route_mask_o & LOW_SEV_FIELDS;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [LANES-1:0] LMASK = lanes_of_bank(b, INPUTS);
        logic wr_b;

        assign lane_tbl[b] = LMASK;
        assign wr_b = bank_wr_i && (reg_kind == BANK_INJECT) && inject_ok
                      && (int'(bank_sel_i) == b);

        lock_inject_bank #(.LANE_MASK(LMASK)) u_inj (
            .clk     (clk),
            .rst     (rst),
            .wr_i    (wr_b),
            .data_i  (bank_data_i[LANES-1:0]),
            .clear_i (lock_set),
            .bits_o  (inject_o[b*LANES +: LANES])
        );
    end

    lock_reload_reg #(.W(CNT_W)) u_reload (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (reload_wr_i),
        .data_i   (reload_data_i),
        .frozen_i (ctrl.lock),
        .value_o  (reload_o)
    );

    assign enable_o    = ctrl.en;
    assign lock_o      = ctrl.lock;
    assign inject_en_o = ctrl.inj_en;

endmodule

// File: rtl/safety_cfg_lock_chk.sv
module safety_cfg_lock_chk #(
    parameter bit HAS_LOCK = 1'b1,
    parameter int INJ_W    = 32,
    parameter int CNT_W    = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             enable_o,
    input logic             lock_o,
    input logic             inject_en_o,
    input logic             route_wr_o,
    input logic [31:0]      route_mask_o,
    input logic [INJ_W-1:0] inject_o,
    input logic [CNT_W-1:0] reload_o
);

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_o |=> lock_o); // R3

    AST_LOCK_CLEARS_INJECT: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> (!inject_en_o && inject_o == '0)); // R4

    AST_NO_INJEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lock_o |-> !inject_en_o); // R5

    AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (rst)
        (lock_o && enable_o) |=> enable_o); // R6

    AST_HIGH_FIELDS_MASKED: assert property (@(posedge clk) disable iff (rst)
        (route_wr_o && lock_o) |-> (route_mask_o[31:16] == 16'h0)); // R8

    AST_INJECT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        lock_o |=> $stable(inject_o)); // R9

    AST_RELOAD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        lock_o |=> $stable(reload_o)); // R10

    if (!HAS_LOCK) begin : g_nolock
        AST_LOCK_ABSENT: assert property (@(posedge clk) disable iff (rst)
            !lock_o); // R11
    end

endmodule

bind safety_cfg_lock safety_cfg_lock_chk #(
    .HAS_LOCK (HAS_LOCK),
    .INJ_W    (INJ_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .enable_o     (enable_o),
    .lock_o       (lock_o),
    .inject_en_o  (inject_en_o),
    .route_wr_o   (route_wr_o),
    .route_mask_o (route_mask_o),
    .inject_o     (inject_o),
    .reload_o     (reload_o)
);

// File: tb/safety_cfg_lock_test.sv
module safety_cfg_lock_test;

    localparam int INPUTS = 20;
    localparam int CNT_W  = 16;
    localparam int NBANK  = 3;
    localparam int BANK_W = 2;
    localparam int INJ_W  = NBANK * 8;

    localparam int S_EN = 0, S_LOCK = 1, S_INJEN = 2, S_INJ = 3, S_RELOAD = 4,
                   S_RWR = 5, S_RMASK = 6, S_RBANK = 7, S_RDATA = 8,
                   S_NL_LOCK = 9, S_NL_RELOAD = 10;

    typedef struct {
        string       tag;
        int          sig;
        logic [31:0] exp;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctrl_wr = 1'b0;
    logic [2:0]        ctrl_data = '0;
    logic              bank_wr = 1'b0;
    logic              bank_reg = 1'b0;
    logic [BANK_W-1:0] bank_sel = '0;
    logic [31:0]       bank_data = '0;
    logic              reload_wr = 1'b0;
    logic [CNT_W-1:0]  reload_data = '0;

    logic              enable, lock, inj_en, route_wr;
    logic [BANK_W-1:0] route_bank;
    logic [31:0]       route_mask, route_data;
    logic [INJ_W-1:0]  inject;
    logic [CNT_W-1:0]  reload;

    logic              nl_enable, nl_lock, nl_inj_en, nl_route_wr;
    logic [BANK_W-1:0] nl_route_bank;
    logic [31:0]       nl_route_mask, nl_route_data;
    logic [INJ_W-1:0]  nl_inject;
    logic [CNT_W-1:0]  nl_reload;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    safety_cfg_lock #(.INPUTS(INPUTS), .CNT_W(CNT_W), .HAS_LOCK(1'b1)) uut (
        .clk(clk), .rst(rst), .ctrl_wr_i(ctrl_wr), .ctrl_data_i(ctrl_data),
        .bank_wr_i(bank_wr), .bank_reg_i(bank_reg), .bank_sel_i(bank_sel),
        .bank_data_i(bank_data), .reload_wr_i(reload_wr), .reload_data_i(reload_data),
        .enable_o(enable), .lock_o(lock), .inject_en_o(inj_en), .route_wr_o(route_wr),
        .route_bank_o(route_bank), .route_mask_o(route_mask), .route_data_o(route_data),
        .inject_o(inject), .reload_o(reload)
    );

    safety_cfg_lock #(.INPUTS(INPUTS), .CNT_W(CNT_W), .HAS_LOCK(1'b0)) uut_nolock (
        .clk(clk), .rst(rst), .ctrl_wr_i(ctrl_wr), .ctrl_data_i(ctrl_data),
        .bank_wr_i(bank_wr), .bank_reg_i(bank_reg), .bank_sel_i(bank_sel),
        .bank_data_i(bank_data), .reload_wr_i(reload_wr), .reload_data_i(reload_data),
        .enable_o(nl_enable), .lock_o(nl_lock), .inject_en_o(nl_inj_en),
        .route_wr_o(nl_route_wr), .route_bank_o(nl_route_bank),
        .route_mask_o(nl_route_mask), .route_data_o(nl_route_data),
        .inject_o(nl_inject), .reload_o(nl_reload)
    );

    function automatic logic [31:0] observe(input int sig);
        case (sig)
            S_EN:        return 32'(enable);
            S_LOCK:      return 32'(lock);
            S_INJEN:     return 32'(inj_en);
            S_INJ:       return 32'(inject);
            S_RELOAD:    return 32'(reload);
            S_RWR:       return 32'(route_wr);
            S_RMASK:     return route_mask;
            S_RBANK:     return 32'(route_bank);
            S_RDATA:     return route_data;
            S_NL_LOCK:   return 32'(nl_lock);
            S_NL_RELOAD: return 32'(nl_reload);
            default:     return 32'hDEAD_BEEF;
        endcase
    endfunction

    task automatic push_exp(input string tag, input int sig, input logic [31:0] v);
        item_t it;
        it.tag = tag;
        it.sig = sig;
        it.exp = v;
        q.push_back(it);
    endtask

    // monitor: compares queued expectations shortly after each falling edge
    always @(negedge clk) begin
        #2;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = observe(it.sig);
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s sig=%0d actual=%h expected=%h", it.tag, it.sig, act, it.exp);
            end
        end
    end

    task automatic ctrl_write(input logic [2:0] d);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_data = d;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic inject_write(input int b, input logic [31:0] d);
        @(negedge clk);
        bank_wr = 1'b1;
        bank_reg = 1'b1;
        bank_sel = BANK_W'(b);
        bank_data = d;
        @(negedge clk);
        bank_wr = 1'b0;
    endtask

    task automatic reload_write(input logic [CNT_W-1:0] d);
        @(negedge clk);
        reload_wr = 1'b1;
        reload_data = d;
        @(negedge clk);
        reload_wr = 1'b0;
    endtask

    task automatic route_write(input string tag, input int b, input logic [31:0] d,
                               input logic exp_wr, input logic [31:0] exp_mask);
        @(negedge clk);
        bank_wr = 1'b1;
        bank_reg = 1'b0;
        bank_sel = BANK_W'(b);
        bank_data = d;
        push_exp(tag, S_RWR, 32'(exp_wr));
        if (exp_wr) begin
            push_exp(tag, S_RMASK, exp_mask);
            push_exp(tag, S_RBANK, 32'(b));
            push_exp(tag, S_RDATA, d);
        end
        @(negedge clk);
        bank_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        push_exp("R1 enable", S_EN, 0);
        push_exp("R1 lock", S_LOCK, 0);
        push_exp("R1 inj_en", S_INJEN, 0);
        push_exp("R1 inject", S_INJ, 0);
        push_exp("R1 reload", S_RELOAD, 0);

        ctrl_write(3'b101);
        push_exp("R2 enable set", S_EN, 1);
        push_exp("R2 lock clear", S_LOCK, 0);
        push_exp("R2 inj_en set", S_INJEN, 1);

        route_write("R7 full bank", 1, 32'hA5A5_1234, 1'b1, 32'hFFFF_FFFF);
        route_write("R7 partial bank", 2, 32'h0102_0304, 1'b1, 32'h0F0F_0F0F);
        route_write("R7 bank out of range", 3, 32'h1111_1111, 1'b0, 32'h0);

        inject_write(0, 32'h0000_00FF);
        push_exp("R9 inject bank0", S_INJ, 32'h0000_00FF);
        inject_write(2, 32'hFFFF_FFFF);
        push_exp("R9 inject partial bank", S_INJ, 32'h000F_00FF);

        reload_write(16'h1234);
        push_exp("R10 reload unlocked", S_RELOAD, 32'h1234);

        ctrl_write(3'b100);
        push_exp("R2 enable cleared", S_EN, 0);
        push_exp("R2 inj_en kept", S_INJEN, 1);

        ctrl_write(3'b110);
        push_exp("R4 lock set", S_LOCK, 1);
        push_exp("R4 inj_en cleared", S_INJEN, 0);
        push_exp("R4 inject zeroed", S_INJ, 0);
        push_exp("R2 enable stays 0", S_EN, 0);
        push_exp("R11 nolock lock reads 0", S_NL_LOCK, 0);

        ctrl_write(3'b000);
        push_exp("R3 lock sticky", S_LOCK, 1);

        ctrl_write(3'b100);
        push_exp("R5 inj_en blocked", S_INJEN, 0);

        ctrl_write(3'b001);
        push_exp("R6 enable set while locked", S_EN, 1);
        ctrl_write(3'b000);
        push_exp("R6 enable clear ignored", S_EN, 1);
        push_exp("R3 lock still set", S_LOCK, 1);

        route_write("R8 locked mask full", 0, 32'hFFFF_FFFF, 1'b1, 32'h0000_FFFF);
        route_write("R8 locked mask partial", 2, 32'hFFFF_FFFF, 1'b1, 32'h0000_0F0F);

        inject_write(0, 32'h0000_0003);
        push_exp("R9 inject ignored locked", S_INJ, 0);

        reload_write(16'h00FF);
        push_exp("R10 reload frozen", S_RELOAD, 32'h1234);
        push_exp("R11 nolock reload accepted", S_NL_RELOAD, 32'h00FF);
        push_exp("R11 nolock lock still 0", S_NL_LOCK, 0);

        @(negedge clk);
        #4;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule